// File: doc/BRIEF.md
# USB Host Controller Command and Status Register Block

This block holds the software-visible control state of a USB 1.1 host controller that walks a frame-based schedule. It keeps the command word, the status word, the interrupt-enable mask, the 11-bit frame number and the 4 KiB-aligned frame-list base. It turns each 1 ms frame tick into a frame-number step while running and presents the address of the frame-list slot for the current frame. From these registers it drives one level-sensitive interrupt request, a halted flag and a one-cycle bus-reset strobe.

The transfer engine reports per-descriptor outcomes on single-cycle event pins. Completion and short-packet events are not shown to software at once. They are gathered during the frame and released at the next frame tick, so software sees at most one completion interrupt per frame. Two hidden cause bits record which kinds of completion were released, and each is gated by its own enable bit.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready handshake and no back-pressure: every write takes effect at the clock edge on which `reg_wr_en` is high. Event pins are level-sampled once per cycle.

Top module: `uhc_regs`

## Requirements
- R1: After reset, command, interrupt enable, frame number and frame-list base read 0, status reads 0x0020 (halted only), and `irq`, `bus_reset` are low with `halted` high.
- R2: Register index 0 is the command word, with run = bit 0. Writing run as 1 when it was 0 clears halted (status bit 5). Writing run as 0 sets halted. A frame tick while run is 0 sets halted. Software cannot clear the halted bit through the status word.
- R3: Each frame tick while run is 1 advances the frame number (index 3) by one modulo 2048. Without a tick it holds.
- R4: A frame-number write is masked to 11 bits and takes effect only while halted. While running it is ignored.
- R5: The frame-list base write drops address bits 11..0. `list_entry_addr` equals the base plus four times frame-number bits 9..0.
- R6: Completion events (`td_ioc`, `td_short`) raised during a frame set nothing visible until the next frame tick while running. At that tick the status USB-interrupt bit (bit 0) and the matching hidden cause bits are set.
- R7: The interrupt-enable word (index 2) keeps bits 3..0. `irq` follows the completion cause with enable bit 2 and the short-packet cause with enable bit 3.
- R8: `td_err` sets status bit 1 in the next cycle, which raises `irq` with enable bit 0. The resume-detect status bit 2 raises `irq` with enable bit 1.
- R9: `sys_err` (status bit 3) and `proc_err` (status bit 4) raise `irq` regardless of the enable word.
- R10: Writing 1 to status bits 4..0 clears them, and writing 1 to bit 0 also clears both hidden cause bits. An event in the same cycle takes precedence over the clear.
- R11: `resume_req` while the suspend bit (command bit 3) is set sets force-resume (command bit 4) and resume detect (status bit 2). Without suspend it has no effect.
- R12: A command write with bit 1 set returns every register, including the base and hidden state, to its R1 value at that edge. Bit 1 always reads 0.
- R13: A command write with bit 2 set stores the bit and pulses `bus_reset` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write index: 0 command, 1 status, 2 enable, 3 frame number |
| reg_wr_data | input | 16 | Write data |
| reg_rd_addr | input | 2 | Read index, same map |
| reg_rd_data | output | 16 | Combinational read data |
| base_wr_en | input | 1 | Frame-list base write strobe |
| base_wr_data | input | 32 | Frame-list base write data |
| base_rd_data | output | 32 | Frame-list base read data |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| td_ioc | input | 1 | Completion-with-interrupt event |
| td_short | input | 1 | Short-packet event |
| td_err | input | 1 | Transfer error event |
| sys_err | input | 1 | Host system error event |
| proc_err | input | 1 | Schedule process error event |
| resume_req | input | 1 | Remote resume request |
| irq | output | 1 | Interrupt request level |
| list_entry_addr | output | 32 | Address of the current frame-list slot |
| halted | output | 1 | Controller halted |
| bus_reset | output | 1 | One-cycle bus reset strobe |

## Verification
The assertions assume that event pins are synchronous and single-cycle. They also assume that a frame tick never coincides with a command write that changes run, because the write's effect on halted takes priority in that cycle. The stimulus drives every input on the falling edge, keeps ticks and register writes in separate cycles, and raises each event for one cycle only. This keeps every clocked property within its stated precondition while still covering wraparound, deferral and same-edge reset.

// File: rtl/uhc_pkg.sv
package uhc_pkg;
  localparam int REG_W  = 16;
  localparam int CMD_W  = 5;
  localparam int STS_W  = 5;
  localparam int IEN_W  = 4;

  typedef enum logic [1:0] {
    RA_CMD  = 2'd0,
    RA_STS  = 2'd1,
    RA_IEN  = 2'd2,
    RA_FNUM = 2'd3
  } reg_idx_e;

  // command bits
  localparam int C_RUN  = 0;
  localparam int C_HCR  = 1;
  localparam int C_GRST = 2;
  localparam int C_SUSP = 3;
  localparam int C_FRES = 4;

  // status bits (halted lives at bit 5, owned by the command logic)
  localparam int S_INT  = 0;
  localparam int S_ERR  = 1;
  localparam int S_RES  = 2;
  localparam int S_SYS  = 3;
  localparam int S_PROC = 4;

  // enable bits
  localparam int E_ERR  = 0;
  localparam int E_RES  = 1;
  localparam int E_IOC  = 2;
  localparam int E_SPK  = 3;
endpackage

// File: rtl/uhc_cmd_ctl.sv
module uhc_cmd_ctl
  import uhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             frame_tick,
  input  logic             resume_req,
  output logic [CMD_W-1:0] cmd_q,
  output logic             halted,
  output logic             bus_rst,
  output logic             resume_hit
);
  localparam logic [CMD_W-1:0] STORE_MASK = ~(CMD_W'(1) << C_HCR);

  assign resume_hit = resume_req && cmd_q[C_SUSP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      halted  <= 1'b1;
      bus_rst <= 1'b0;
    end else begin
      bus_rst <= cmd_we && cmd_wdata[C_GRST];
      if (clr) begin
        cmd_q  <= '0;
        halted <= 1'b1;
      end else if (cmd_we) begin
        cmd_q <= cmd_wdata & STORE_MASK;
        if (cmd_wdata[C_RUN] && !cmd_q[C_RUN])
          halted <= 1'b0;
        else if (!cmd_wdata[C_RUN])
          halted <= 1'b1;
      end else begin
        if (resume_hit)
          cmd_q[C_FRES] <= 1'b1;
        if (frame_tick && !cmd_q[C_RUN])
          halted <= 1'b1;
      end
    end
  end

  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr && cmd_wdata[C_RUN] && !cmd_q[C_RUN]) |=> !halted);
  // R2
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr && !cmd_wdata[C_RUN]) |=> halted);
  // R2
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !cmd_we && !cmd_q[C_RUN]) |=> halted);
  // R13
  grst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[C_GRST]) |=> bus_rst);
  // R11
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && cmd_q[C_SUSP] && !cmd_we && !clr) |=> cmd_q[C_FRES]);
endmodule

// File: rtl/uhc_frame_ctr.sv
module uhc_frame_ctr #(
  parameter int FN_W     = 11,
  parameter int IDX_W    = 10,
  parameter int AW       = 32,
  parameter int BASE_LSB = 12,
  parameter int SLOT_SH  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic            fn_we,
  input  logic [FN_W-1:0] fn_wdata,
  input  logic            base_we,
  input  logic [AW-1:0]   base_wdata,
  output logic [FN_W-1:0] fnum,
  output logic [AW-1:0]   base_q,
  output logic [AW-1:0]   entry_addr
);
  localparam int HI_W = AW - BASE_LSB;

  logic [HI_W-1:0] base_hi;

  assign base_q     = {base_hi, {BASE_LSB{1'b0}}};
  assign entry_addr = base_q + AW'({fnum[IDX_W-1:0], {SLOT_SH{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fnum    <= '0;
      base_hi <= '0;
    end else if (clr) begin
      fnum    <= '0;
      base_hi <= '0;
    end else begin
      if (step)
        fnum <= fnum + 1'b1;
      else if (fn_we)
        fnum <= fn_wdata;
      if (base_we)
        base_hi <= base_wdata[AW-1:BASE_LSB];
    end
  end

  // R3
  fn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> fnum == ($past(fnum) + 1'b1));
  // R3
  fn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !fn_we && !clr) |=> $stable(fnum));
  // R5
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_we && !clr) |=> $stable(base_q));
endmodule

// File: rtl/uhc_int_ctl.sv
module uhc_int_ctl
  import uhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             ev_ioc,
  input  logic             ev_short,
  input  logic             ev_err,
  input  logic             ev_sys,
  input  logic             ev_proc,
  input  logic             ev_resume,
  input  logic             sts_we,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             ien_we,
  input  logic [IEN_W-1:0] ien_wdata,
  output logic [STS_W-1:0] sts_q,
  output logic [IEN_W-1:0] ien_q,
  output logic             irq
);
  logic [1:0]       pending, cause, cause_nx, pend_nx;
  logic [STS_W-1:0] sts_nx;
  logic             release_now;

  assign release_now = step && (|pending);

  always_comb begin
    pend_nx = step ? {ev_short, ev_ioc} : (pending | {ev_short, ev_ioc});

    cause_nx = cause;
    if (sts_we && sts_wdata[S_INT]) cause_nx = '0;
    if (release_now) cause_nx = cause_nx | pending;

    sts_nx = sts_q;
    if (sts_we) sts_nx = sts_nx & ~sts_wdata;
    if (release_now) sts_nx[S_INT]  = 1'b1;
    if (ev_err)      sts_nx[S_ERR]  = 1'b1;
    if (ev_resume)   sts_nx[S_RES]  = 1'b1;
    if (ev_sys)      sts_nx[S_SYS]  = 1'b1;
    if (ev_proc)     sts_nx[S_PROC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      cause   <= '0;
      sts_q   <= '0;
      ien_q   <= '0;
    end else if (clr) begin
      pending <= '0;
      cause   <= '0;
      sts_q   <= '0;
      ien_q   <= '0;
    end else begin
      pending <= pend_nx;
      cause   <= cause_nx;
      sts_q   <= sts_nx;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  assign irq = (cause[0] && ien_q[E_IOC]) ||
               (cause[1] && ien_q[E_SPK]) ||
               (sts_q[S_ERR] && ien_q[E_ERR]) ||
               (sts_q[S_RES] && ien_q[E_RES]) ||
               sts_q[S_SYS] || sts_q[S_PROC];

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (|pending) && !clr) |=> sts_q[S_INT]);
  // R6
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[S_INT]) |-> $past(step));
  // R9
  unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_sys || ev_proc) && !clr) |=> irq);
  // R10
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && sts_wdata[S_INT] && !step && !clr) |=> cause == 2'b00);
endmodule

// File: rtl/uhc_regs.sv
module uhc_regs
  import uhc_pkg::*;
#(
  parameter int FN_W     = 11,
  parameter int IDX_W    = 10,
  parameter int AW       = 32,
  parameter int BASE_LSB = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_addr,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [1:0]       reg_rd_addr,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             base_wr_en,
  input  logic [AW-1:0]    base_wr_data,
  output logic [AW-1:0]    base_rd_data,
  input  logic             frame_tick,
  input  logic             td_ioc,
  input  logic             td_short,
  input  logic             td_err,
  input  logic             sys_err,
  input  logic             proc_err,
  input  logic             resume_req,
  output logic             irq,
  output logic [AW-1:0]    list_entry_addr,
  output logic             halted,
  output logic             bus_reset
);
  logic             cmd_we, sts_we, ien_we, fn_we, hc_clr, step, resume_hit;
  logic [CMD_W-1:0] cmd_q;
  logic [STS_W-1:0] sts_q;
  logic [IEN_W-1:0] ien_q;
  logic [FN_W-1:0]  fnum;
  logic             unused_wdata;

  assign unused_wdata = &{1'b0, reg_wr_data[REG_W-1:FN_W]};

  assign cmd_we = reg_wr_en && (reg_wr_addr == RA_CMD);
  assign sts_we = reg_wr_en && (reg_wr_addr == RA_STS);
  assign ien_we = reg_wr_en && (reg_wr_addr == RA_IEN);
  assign fn_we  = reg_wr_en && (reg_wr_addr == RA_FNUM) && halted;
  assign hc_clr = cmd_we && reg_wr_data[C_HCR];
  assign step   = frame_tick && cmd_q[C_RUN];

  uhc_cmd_ctl u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (hc_clr),
    .cmd_we     (cmd_we),
    .cmd_wdata  (reg_wr_data[CMD_W-1:0]),
    .frame_tick (frame_tick),
    .resume_req (resume_req),
    .cmd_q      (cmd_q),
    .halted     (halted),
    .bus_rst    (bus_reset),
    .resume_hit (resume_hit)
  );

  uhc_frame_ctr #(
    .FN_W     (FN_W),
    .IDX_W    (IDX_W),
    .AW       (AW),
    .BASE_LSB (BASE_LSB),
    .SLOT_SH  (2)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (hc_clr),
    .step       (step),
    .fn_we      (fn_we),
    .fn_wdata   (reg_wr_data[FN_W-1:0]),
    .base_we    (base_wr_en),
    .base_wdata (base_wr_data),
    .fnum       (fnum),
    .base_q     (base_rd_data),
    .entry_addr (list_entry_addr)
  );

  uhc_int_ctl u_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hc_clr),
    .step      (step),
    .ev_ioc    (td_ioc),
    .ev_short  (td_short),
    .ev_err    (td_err),
    .ev_sys    (sys_err),
    .ev_proc   (proc_err),
    .ev_resume (resume_hit),
    .sts_we    (sts_we),
    .sts_wdata (reg_wr_data[STS_W-1:0]),
    .ien_we    (ien_we),
    .ien_wdata (reg_wr_data[IEN_W-1:0]),
    .sts_q     (sts_q),
    .ien_q     (ien_q),
    .irq       (irq)
  );

  always_comb begin
    case (reg_rd_addr)
      RA_CMD:  reg_rd_data = REG_W'(cmd_q);
      RA_STS:  reg_rd_data = REG_W'({halted, sts_q});
      RA_IEN:  reg_rd_data = REG_W'(ien_q);
      default: reg_rd_data = REG_W'(fnum);
    endcase
  end

  // R4
  fn_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == RA_FNUM && !halted && !frame_tick) |=> $stable(fnum));
  // R12
  hc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hc_clr |=> (halted && !irq && cmd_q == '0 && base_rd_data == '0));
endmodule

// File: tb/uhc_regs_test.sv
`timescale 1ns/1ps
module uhc_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = 2'd0;
  logic [15:0] reg_wr_data = 16'd0;
  logic [1:0]  reg_rd_addr = 2'd0;
  logic [15:0] reg_rd_data;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = 32'd0;
  logic [31:0] base_rd_data;
  logic        frame_tick = 1'b0, td_ioc = 1'b0, td_short = 1'b0, td_err = 1'b0;
  logic        sys_err = 1'b0, proc_err = 1'b0, resume_req = 1'b0;
  logic        irq, halted, bus_reset;
  logic [31:0] list_entry_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uhc_regs uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .base_rd_data(base_rd_data),
    .frame_tick(frame_tick), .td_ioc(td_ioc), .td_short(td_short), .td_err(td_err),
    .sys_err(sys_err), .proc_err(proc_err), .resume_req(resume_req),
    .irq(irq), .list_entry_addr(list_entry_addr), .halted(halted), .bus_reset(bus_reset)
  );

  localparam logic [1:0] A_CMD = 2'd0, A_STS = 2'd1, A_IEN = 2'd2, A_FN = 2'd3;

  // {write index, write data, read index, expected read}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {A_IEN, 16'h000F, A_IEN, 16'h000F},   // R7
    {A_IEN, 16'hFFF0, A_IEN, 16'h0000},   // R7
    {A_FN,  16'hFFFF, A_FN,  16'h07FF},   // R4
    {A_FN,  16'h0123, A_FN,  16'h0123},   // R4
    {A_STS, 16'hFFFF, A_STS, 16'h0020},   // R2
    {A_CMD, 16'h0008, A_CMD, 16'h0008},   // R11
    {A_CMD, 16'h0000, A_CMD, 16'h0000}    // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_rd_addr = a;
    #1;
    v = reg_rd_data;
  endtask

  // {resume, proc, sys, err, short, ioc, tick}
  task automatic ev(input logic [6:0] b);
    @(negedge clk);
    {resume_req, proc_err, sys_err, td_err, td_short, td_ioc, frame_tick} = b;
    @(negedge clk);
    {resume_req, proc_err, sys_err, td_err, td_short, td_ioc, frame_tick} = '0;
  endtask

  task automatic tick();
    ev(7'b0000001);
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, {16'd0, v}, {16'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg("R1 cmd", A_CMD, 16'h0000);
    chk_reg("R1 sts", A_STS, 16'h0020);
    chk_reg("R1 ien", A_IEN, 16'h0000);
    chk_reg("R1 fn",  A_FN,  16'h0000);
    chk("R1 base", base_rd_data, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 halted", {31'd0, halted}, 32'd1);
    chk("R1 bus_reset", {31'd0, bus_reset}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      wr(VEC[i][35:34], VEC[i][33:18]);
      rd(VEC[i][17:16], v);
      chk($sformatf("vector %0d (R2/R4/R7/R11)", i), {16'd0, v}, {16'd0, VEC[i][15:0]});
    end

    // R5 base masking and entry address
    @(negedge clk); base_wr_en = 1'b1; base_wr_data = 32'h12345FFF;
    @(negedge clk); base_wr_en = 1'b0;
    chk("R5 base", base_rd_data, 32'h12345000);
    chk("R5 entry", list_entry_addr, 32'h1234548C);
    wr(A_FN, 16'h07FF);
    chk("R5 entry idx10", list_entry_addr, 32'h12345FFC);

    // R2 run, R4 write ignored while running
    wr(A_CMD, 16'h0001);
    chk("R2 halted clr", {31'd0, halted}, 32'd0);
    chk_reg("R2 sts run", A_STS, 16'h0000);
    wr(A_FN, 16'h0010);
    chk_reg("R4 fn locked", A_FN, 16'h07FF);

    // R3 wrap and step
    tick();
    chk_reg("R3 wrap", A_FN, 16'h0000);
    chk("R5 entry wrap", list_entry_addr, 32'h12345000);
    tick();
    chk_reg("R3 step", A_FN, 16'h0001);

    // R6/R7 deferred completion
    wr(A_IEN, 16'h0004);
    ev(7'b0000010);
    chk_reg("R6 deferred sts", A_STS, 16'h0000);
    chk("R6 deferred irq", {31'd0, irq}, 32'd0);
    tick();
    chk_reg("R6 released", A_STS, 16'h0001);
    chk("R7 ioc irq", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0001);
    chk_reg("R10 int clr", A_STS, 16'h0000);
    chk("R10 cause clr", {31'd0, irq}, 32'd0);

    // R7 short-packet cause
    ev(7'b0000100);
    tick();
    chk_reg("R6 short released", A_STS, 16'h0001);
    chk("R7 short masked", {31'd0, irq}, 32'd0);
    wr(A_IEN, 16'h0008);
    chk("R7 short enabled", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0001);
    chk("R10 short clr", {31'd0, irq}, 32'd0);

    // R8 error interrupt
    ev(7'b0001000);
    chk_reg("R8 err sts", A_STS, 16'h0002);
    chk("R8 err masked", {31'd0, irq}, 32'd0);
    wr(A_IEN, 16'h0001);
    chk("R8 err enabled", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0002);
    chk_reg("R10 err clr", A_STS, 16'h0000);

    // R9 unmaskable errors
    wr(A_IEN, 16'h0000);
    ev(7'b0010000);
    chk_reg("R9 sys sts", A_STS, 16'h0008);
    chk("R9 sys irq", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0008);
    chk("R10 sys clr", {31'd0, irq}, 32'd0);
    ev(7'b0100000);
    chk_reg("R9 proc sts", A_STS, 16'h0010);
    chk("R9 proc irq", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0010);
    chk("R10 proc clr", {31'd0, irq}, 32'd0);

    // R11 resume
    ev(7'b1000000);
    chk_reg("R11 ignored cmd", A_CMD, 16'h0001);
    chk_reg("R11 ignored sts", A_STS, 16'h0000);
    wr(A_CMD, 16'h0009);
    ev(7'b1000000);
    chk_reg("R11 cmd fres", A_CMD, 16'h0019);
    chk_reg("R11 sts rd", A_STS, 16'h0004);
    wr(A_IEN, 16'h0002);
    chk("R8 resume irq", {31'd0, irq}, 32'd1);
    wr(A_STS, 16'h0004);
    chk("R10 resume clr", {31'd0, irq}, 32'd0);

    // R2 stop, R3 hold while halted
    wr(A_CMD, 16'h0000);
    chk_reg("R2 stop sts", A_STS, 16'h0020);
    tick();
    chk_reg("R3 hold", A_FN, 16'h0003);
    chk("R2 tick halted", {31'd0, halted}, 32'd1);

    // R13 bus reset strobe
    wr(A_CMD, 16'h0004);
    chk("R13 pulse", {31'd0, bus_reset}, 32'd1);
    chk_reg("R13 stored", A_CMD, 16'h0004);
    @(negedge clk);
    chk("R13 one cycle", {31'd0, bus_reset}, 32'd0);

    // R12 controller reset
    wr(A_IEN, 16'h000F);
    wr(A_CMD, 16'h0001);
    ev(7'b0010000);
    wr(A_CMD, 16'h0003);
    chk_reg("R12 cmd", A_CMD, 16'h0000);
    chk_reg("R12 sts", A_STS, 16'h0020);
    chk_reg("R12 ien", A_IEN, 16'h0000);
    chk_reg("R12 fn",  A_FN,  16'h0000);
    chk("R12 base", base_rd_data, 32'h0);
    chk("R12 irq", {31'd0, irq}, 32'd0);
    chk("R12 halted", {31'd0, halted}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule